// File: doc/BRIEF.md
# IDCODE Pin Pair Scanner

This block searches a bank of probe pins for the clock and data-out lines of an unknown test port. After reset, a target that has an identification register connects it to its data output. The target then shifts the register out on each clock pulse, whatever levels its mode-select and data-in lines carry. The scanner tries every ordered pair of probe pins. It drives one pin of the pair as a candidate test clock and samples the other as the candidate data output. Each pair gets a burst of `ID_BITS` clock pulses, and the sampled bits are assembled into a word.

A word is reported only if the line actually changed during the burst and the word looks like a legal identifier. A word of all ones means the line was pulled high and idle. A word of all zeros means the line was held low. A word with bit 0 clear is not a legal identifier. All three are discarded. Each accepted word leaves the block as a one-cycle result beat that carries the clock pin index, the data pin index and the word.

While a pair is under test, every pin other than the candidate clock is an input with its pull-up enabled. A fixed number of idle system clocks, with no pin driven, separates successive pairs. A single `start` pulse runs the whole sweep, and `done` pulses when the sweep is over.

Top module: `idcode_pair_scanner`

## Requirements
- R1: After reset no probe pin is driven (`pin_oe` all 0, `pin_out` all 0), every pull-up is enabled (`pin_pullup` all 1), and `done` and `res_valid` are low.
- R2: A `start` pulse while idle begins a sweep over all `NUM_PINS*(NUM_PINS-1)` ordered pairs. The clock index is the outer loop and counts up from 0. The data index is the inner loop, counts up from 0 and skips the clock index. Results leave in that order.
- R3: While a pair is under test, exactly one pin is driven: the clock candidate, with `pin_oe` at 1 and `pin_pullup` at 0 on that pin. Every other pin has `pin_oe` at 0 and `pin_pullup` at 1.
- R4: Each pair receives exactly `ID_BITS` clock pulses. A pulse is a low phase of `TCK_HALF` system clocks followed by a high phase of `TCK_HALF` system clocks, and the line starts low.
- R5: One bit is captured per pulse, at the end of the pulse's high phase, from the data candidate through a two-stage synchronizer. The first captured bit becomes bit 0 of `res_word`. With `TCK_HALF` of 3 or more, a target that updates its output within one system clock after a falling clock edge is read correctly.
- R6: A captured word of all ones is discarded, and no result beat is produced for it.
- R7: A captured word of all zeros is discarded.
- R8: A captured word with bit 0 equal to 0 is discarded.
- R9: A word that is not discarded is reported as a single-cycle `res_valid` beat, with `res_tck` and `res_tdo` giving the pin indices of the pair.
- R10: Between two successive pairs, no pin is driven for exactly `IDLE_CLKS+1` system clocks.
- R11: `done` is a one-cycle pulse in the same cycle as the result beat of the last pair, (`NUM_PINS-1`, `NUM_PINS-2`), if that pair yields one. After `done` the scanner is idle and accepts a new `start`.
- R12: A `start` pulse during a sweep has no effect. The sweep is neither restarted nor repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (sampled while idle) |
| pin_in | input | NUM_PINS | Levels read back from the probe pins |
| pin_oe | output | NUM_PINS | Output enable per probe pin |
| pin_out | output | NUM_PINS | Driven level per probe pin |
| pin_pullup | output | NUM_PINS | Pull-up enable per probe pin |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| res_valid | output | 1 | Result beat valid |
| res_tck | output | $clog2(NUM_PINS) | Clock pin index of the result |
| res_tdo | output | $clog2(NUM_PINS) | Data pin index of the result |
| res_word | output | ID_BITS | Captured identification word |

## Verification
The result beat of the final pair and the end-of-sweep pulse are raised by the same register update, so they can fall in one cycle. The bench provokes this by placing a model target on pins 7 (clock) and 6 (data), which is the last pair visited. Its monitor then requires `done` and `res_valid` to be seen high together on the same sample. The scoreboard must also hold no entries after that beat. In a separate sweep, where the last pair yields nothing, the monitor requires that `done` arrives alone.

// File: rtl/idscan_pkg.sv
package idscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_EVAL  = 2'd3
  } scan_st_e;
endpackage

// File: rtl/idscan_pair_seq.sv
// Walks ordered (clock, data) pin pairs, never pairing a pin with itself.
module idscan_pair_seq #(
  parameter int NPINS = 8,
  parameter int IW    = $clog2(NPINS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  output logic [IW-1:0] tck_idx,
  output logic [IW-1:0] tdo_idx,
  output logic          last
);
  localparam logic [IW:0] PIN_CNT  = (IW+1)'(NPINS);
  localparam logic [IW-1:0] TOP_IX = IW'(NPINS - 1);
  localparam logic [IW-1:0] PEN_IX = IW'(NPINS - 2);

  logic [IW:0]   tdo_nx_w;
  logic [IW-1:0] tck_nx;
  logic [IW-1:0] tdo_nx;

  always_comb begin
    tck_nx   = tck_idx;
    tdo_nx_w = {1'b0, tdo_idx} + 1'b1;
    if (tdo_nx_w[IW-1:0] == tck_idx && tdo_nx_w < PIN_CNT)
      tdo_nx_w = tdo_nx_w + 1'b1;
    if (tdo_nx_w >= PIN_CNT) begin
      tck_nx = tck_idx + 1'b1;
      tdo_nx = '0;
    end else begin
      tdo_nx = tdo_nx_w[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      tck_idx <= '0;
      tdo_idx <= IW'(1);
    end else if (step) begin
      tck_idx <= tck_nx;
      tdo_idx <= tdo_nx;
    end
  end

  assign last = (tck_idx == TOP_IX) && (tdo_idx == PEN_IX);

  // R2
  pair_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    tck_idx != tdo_idx);
endmodule

// File: rtl/idscan_tck_gen.sv
// Produces the candidate clock waveform and the bit sampling strobe.
module idscan_tck_gen #(
  parameter int HALF = 4,
  parameter int BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tck_lvl,
  output logic sample,
  output logic word_done
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(BITS);
  localparam logic [PW-1:0] PH_END = PW'(HALF - 1);
  localparam logic [BW-1:0] BIT_END = BW'(BITS - 1);

  logic [PW-1:0] phase;
  logic [BW-1:0] bit_cnt;

  assign sample    = run && tck_lvl && (phase == PH_END);
  assign word_done = sample && (bit_cnt == BIT_END);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase   <= '0;
      tck_lvl <= 1'b0;
      bit_cnt <= '0;
    end else if (phase == PH_END) begin
      phase   <= '0;
      tck_lvl <= ~tck_lvl;
      if (tck_lvl) bit_cnt <= (bit_cnt == BIT_END) ? '0 : bit_cnt + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/idscan_shift_cap.sv
// Synchronizes the data candidate, shifts bits in LSB first, judges the word.
module idscan_shift_cap #(
  parameter int BITS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tdo_raw,
  input  logic            sample,
  output logic [BITS-1:0] word,
  output logic            word_ok
);
  logic sync_a, sync_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
      word   <= '1;
    end else begin
      sync_a <= tdo_raw;
      sync_b <= sync_a;
      if (sample) word <= {sync_b, word[BITS-1:1]};
    end
  end

  logic all_hi, all_lo;
  assign all_hi  = &word;
  assign all_lo  = ~|word;
  assign word_ok = word[0] && !all_hi && !all_lo;
endmodule

// File: rtl/idscan_pin_ctl.sv
// Registered pin drive: one clock candidate driven, all else pulled-up inputs.
module idscan_pin_ctl #(
  parameter int NPINS = 8,
  parameter int BITS  = 32,
  parameter int IW    = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drive,
  input  logic             tck_lvl,
  input  logic [IW-1:0]    tck_idx,
  input  logic [IW-1:0]    tdo_idx,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_pullup,
  output logic             tdo_raw
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic sel;
    assign sel = drive && (tck_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[g]     <= 1'b0;
        pin_out[g]    <= 1'b0;
        pin_pullup[g] <= 1'b1;
      end else begin
        pin_oe[g]     <= sel;
        pin_out[g]    <= sel && tck_lvl;
        pin_pullup[g] <= !sel;
      end
    end
  end

  assign tdo_raw = pin_in[tdo_idx];

  // pulse tally used only by the burst-length check
  localparam int CW = $clog2(BITS + 1);
  logic [NPINS-1:0] out_prev;
  logic [CW-1:0]    rise_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      out_prev <= '0;
      rise_cnt <= '0;
    end else begin
      out_prev <= pin_out & pin_oe;
      if (!(|pin_oe)) rise_cnt <= '0;
      else if (|((pin_out & pin_oe) & ~out_prev)) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R3
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(pin_oe) <= 1);
  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(|pin_oe) |-> (rise_cnt == CW'(BITS)));
endmodule

// File: rtl/idcode_pair_scanner.sv
module idcode_pair_scanner #(
  parameter int NUM_PINS  = 8,
  parameter int ID_BITS   = 32,
  parameter int TCK_HALF  = 4,
  parameter int IDLE_CLKS = 4,
  parameter int IW        = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_pullup,
  output logic                done,
  output logic                res_valid,
  output logic [IW-1:0]       res_tck,
  output logic [IW-1:0]       res_tdo,
  output logic [ID_BITS-1:0]  res_word
);
  import idscan_pkg::*;

  localparam int GW = $clog2(IDLE_CLKS + 1);
  localparam logic [GW-1:0] GAP_END = GW'(IDLE_CLKS - 1);

  scan_st_e st;
  logic [GW-1:0] gap_cnt;
  logic [IW-1:0] tck_idx, tdo_idx;
  logic last_pair, tck_lvl, sample, word_done, tdo_raw, word_ok;
  logic [ID_BITS-1:0] word;
  logic seq_load, seq_step;

  assign seq_load = (st == ST_IDLE) && start;
  assign seq_step = (st == ST_EVAL) && !last_pair;

  idscan_pair_seq #(.NPINS(NUM_PINS), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .load(seq_load), .step(seq_step),
    .tck_idx(tck_idx), .tdo_idx(tdo_idx), .last(last_pair));

  idscan_tck_gen #(.HALF(TCK_HALF), .BITS(ID_BITS)) u_tck (
    .clk(clk), .rst(rst), .run(st == ST_SHIFT),
    .tck_lvl(tck_lvl), .sample(sample), .word_done(word_done));

  idscan_pin_ctl #(.NPINS(NUM_PINS), .BITS(ID_BITS), .IW(IW)) u_pins (
    .clk(clk), .rst(rst), .drive(st == ST_SHIFT), .tck_lvl(tck_lvl),
    .tck_idx(tck_idx), .tdo_idx(tdo_idx), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pullup(pin_pullup),
    .tdo_raw(tdo_raw));

  idscan_shift_cap #(.BITS(ID_BITS)) u_cap (
    .clk(clk), .rst(rst), .tdo_raw(tdo_raw), .sample(sample),
    .word(word), .word_ok(word_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      gap_cnt   <= '0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_tck   <= '0;
      res_tdo   <= '0;
      res_word  <= '0;
    end else begin
      done      <= 1'b0;
      res_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_GAP;
          gap_cnt <= '0;
        end
        ST_GAP: begin
          if (gap_cnt == GAP_END) st <= ST_SHIFT;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        ST_SHIFT: if (word_done) st <= ST_EVAL;
        ST_EVAL: begin
          res_valid <= word_ok;
          res_tck   <= tck_idx;
          res_tdo   <= tdo_idx;
          res_word  <= word;
          gap_cnt   <= '0;
          if (last_pair) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_GAP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  res_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_word[0]);
  // R6
  res_not_ones_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_word != '1));
  // R9
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/idcode_pair_scanner_tb_top.sv
`timescale 1ns/1ps
module idcode_pair_scanner_tb_top;
  localparam int N  = 8;
  localparam int IB = 32;
  localparam int HB = 3;
  localparam int IC = 3;
  localparam int NPAIR = N * (N - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N-1:0] pin_in, pin_oe, pin_out, pin_pullup;
  logic done, res_valid;
  logic [2:0] res_tck, res_tdo;
  logic [IB-1:0] res_word;

  always #2 clk = ~clk;

  idcode_pair_scanner #(.NUM_PINS(N), .ID_BITS(IB), .TCK_HALF(HB), .IDLE_CLKS(IC)) dut_i (
    .clk(clk), .rst(rst), .start(start), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_pullup(pin_pullup), .done(done), .res_valid(res_valid),
    .res_tck(res_tck), .res_tdo(res_tdo), .res_word(res_word));

  // model targets
  logic         t_en  [2];
  int           t_ck  [2];
  int           t_do  [2];
  logic [IB-1:0] t_id [2];
  int           t_cnt [2];
  logic         t_prev[2];

  always @(posedge clk) begin
    for (int t = 0; t < 2; t++) begin
      t_prev[t] <= pin_out[t_ck[t]];
      if (!pin_oe[t_ck[t]]) t_cnt[t] <= 0;
      else if (t_prev[t] && !pin_out[t_ck[t]]) t_cnt[t] <= t_cnt[t] + 1;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pin_in[i] = pin_oe[i] ? pin_out[i] : pin_pullup[i];
      for (int t = 0; t < 2; t++)
        if (t_en[t] && t_do[t] == i && pin_oe[t_ck[t]])
          pin_in[i] = t_id[t][t_cnt[t] % IB];
    end
  end

  typedef struct packed { logic [2:0] ck; logic [2:0] dq; logic [IB-1:0] w; } exp_t;
  exp_t exp_q[$];

  int checks = 0, failures = 0;
  int n_res = 0, n_done = 0, n_done_res = 0, n_pairs = 0;
  int pin_bad = 0, pulse_bad = 0, gap_bad = 0;
  int pulses = 0, low_cnt = 0;
  bit in_gap = 0, prev_any = 0, finished = 0;
  logic [N-1:0] prev_drv = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        n_res++;
        if (exp_q.size() == 0) chk(0, "R9", "unexpected result", {res_tck, res_tdo, res_word}, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({res_tck, res_tdo, res_word} == e, "R5", "result beat",
              {res_tck, res_tdo, res_word}, e);
        end
      end
      if (done) begin
        n_done++;
        if (res_valid) n_done_res++;
      end
      if ($countones(pin_oe) > 1 || pin_pullup != ~pin_oe) pin_bad++;
      if (|((pin_out & pin_oe) & ~prev_drv)) pulses++;
      prev_drv = pin_out & pin_oe;
      if (prev_any && !(|pin_oe)) begin
        n_pairs++;
        if (pulses != IB) pulse_bad++;
        pulses = 0;
        in_gap = 1;
        low_cnt = 1;
      end else if (in_gap && !(|pin_oe)) low_cnt++;
      else if (in_gap && (|pin_oe)) begin
        if (low_cnt != IC + 1) gap_bad++;
        in_gap = 0;
      end
      prev_any = |pin_oe;
    end
  end

  function automatic bit good_word(logic [IB-1:0] w);
    return w[0] && (w != '0) && (w != '1);
  endfunction

  // driver: pushes expected beats, runs one sweep, checks sweep-level rules
  task automatic run_scan(input string tag, input bit poke_mid, input bit want_done_res);
    int r0, d0, dr0, p0, pb0, ub0, gb0, nexp;
    nexp = 0;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (a != b) begin
          logic [IB-1:0] w;
          w = '1;
          for (int t = 0; t < 2; t++)
            if (t_en[t] && t_ck[t] == a && t_do[t] == b) w = t_id[t];
          if (good_word(w)) begin
            exp_q.push_back({3'(a), 3'(b), w});
            nexp++;
          end
        end
    r0 = n_res; d0 = n_done; dr0 = n_done_res; p0 = n_pairs;
    pb0 = pin_bad; ub0 = pulse_bad; gb0 = gap_bad;
    in_gap = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke_mid) begin
      repeat (700) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (n_done == d0) @(posedge clk);
    repeat (20) @(negedge clk);
    $display("sweep %s finished", tag);
    chk(n_res - r0 == nexp, "R9", "result count", n_res - r0, nexp);
    chk(exp_q.size() == 0, "R2", "missing results", exp_q.size(), 0);
    chk(n_pairs - p0 == NPAIR, "R2", "pairs visited", n_pairs - p0, NPAIR);
    chk(pin_bad == pb0, "R3", "pin drive rule breaks", pin_bad - pb0, 0);
    chk(pulse_bad == ub0, "R4", "bursts of wrong length", pulse_bad - ub0, 0);
    chk(gap_bad == gb0, "R10", "gaps of wrong length", gap_bad - gb0, 0);
    chk(n_done - d0 == 1, "R12", "done pulses in sweep", n_done - d0, 1);
    chk((n_done_res - dr0) == int'(want_done_res), "R11", "done with last result",
        n_done_res - dr0, want_done_res);
    chk(pin_oe == '0 && pin_pullup == '1, "R11", "idle after done", pin_oe, 0);
    exp_q.delete();
  endtask

  initial begin
    for (int t = 0; t < 2; t++) begin
      t_en[t] = 0; t_ck[t] = 0; t_do[t] = 1; t_id[t] = '0;
    end
    repeat (4) @(negedge clk);
    chk(pin_oe == '0 && pin_out == '0, "R1", "pins in reset", {pin_oe, pin_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pin_oe == '0 && pin_out == '0 && pin_pullup == '1, "R1", "pins after reset",
        {pin_oe, pin_out, pin_pullup}, {16'h0, 8'hff});
    chk(!done && !res_valid, "R1", "flags after reset", {done, res_valid}, 0);

    // R5 one target, asymmetric word shows bit order
    t_en[0] = 1; t_ck[0] = 2; t_do[0] = 5; t_id[0] = 32'h1234_5679;
    run_scan("single", 0, 0);
    // R6 all-ones word discarded
    t_id[0] = 32'hFFFF_FFFF;
    run_scan("ones", 0, 0);
    // R7 all-zeros word discarded
    t_id[0] = 32'h0000_0000;
    run_scan("zeros", 0, 0);
    // R8 bit 0 clear discarded
    t_id[0] = 32'hABCD_0010;
    run_scan("lsb0", 0, 0);
    // R11 last pair yields a result; R12 start poked mid sweep
    t_ck[0] = 7; t_do[0] = 6; t_id[0] = 32'h0F0F_1E3D;
    t_en[1] = 1; t_ck[1] = 0; t_do[1] = 1; t_id[1] = 32'h8000_0001;
    run_scan("edges", 1, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule